// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

The block collects 64 level-sensitive interrupt lines and turns them into two level requests toward a processor: a normal request and a fast request. Every source carries an enable bit, a routing bit that sends it to one of the two requests, a 4-bit priority and a software force bit. Software reaches all of this through a flat 32-bit register port with a combinational read path and single-cycle writes. Every per-source vector is split across two words, a low word for sources 0–31 and a high word for sources 32–63.

A software handler reads the normal vector word to learn which pending normal source to serve. That source is the one with the highest priority, and ties go to the higher source number. A programmable mask level can hide sources whose priority is too low. The fast vector word names the highest-numbered fast-pending source. Single enable bits can be set or cleared by writing a source number to one of two command words, so software does no read-modify-write.

Top module: `vec_intc`

## Requirements
- R1: After reset the following hold. All enable, routing, force and priority fields are 0. The control word is 0 and the mask level reads 0x1F. Both vector words read 0xFFFFFFFF and both requests are low.
- R2: Word offsets are fixed: 0x00 control, 0x04 mask level, 0x08 set-enable-by-number, 0x0C clear-enable-by-number, 0x10/0x14 enable, 0x18/0x1C routing, 0x20–0x3C priority, 0x40 normal vector, 0x44 fast vector, 0x48/0x4C raw level, 0x50/0x54 force, 0x58/0x5C normal pending, 0x60/0x64 fast pending. In each high/low pair the first offset is the high word. Bit k of a low word is source k, and bit k of a high word is source 32+k. Reads at other offsets return 0.
- R3: Writing a value n in 0..63 to 0x08 sets enable bit n, and writing it to 0x0C clears enable bit n. No other enable bit changes. A written value above 63 changes nothing.
- R4: Source levels are sampled into a register on each clock. A source is pending when (sampled level OR force bit) AND enable bit. A pending source with routing bit 0 is normal-pending, and one with routing bit 1 is fast-pending.
- R5: The normal request output is the OR of all normal-pending bits, and the fast request output is the OR of all fast-pending bits. Masking does not affect either output.
- R6: The priority word at offset 0x20 + 4*(7−x) holds the 4-bit priorities of sources 8x..8x+7. Source 8x+j sits in bits 4j+3:4j.
- R7: The normal vector word returns {source number, priority} in bits 31:16 and 15:0. It picks the eligible normal-pending source with the highest priority, and on a tie the higher source number wins. It reads 0xFFFFFFFF when no source is eligible.
- R8: When the mask level is 0x1F every normal-pending source is eligible. Otherwise only sources whose priority is strictly greater than the mask level are eligible.
- R9: The fast vector word returns {number, priority} of the highest-numbered fast-pending source, or 0xFFFFFFFF when none is fast-pending. Priority, ties and mask level play no part in this choice.
- R10: Writes to the vector, raw-level and pending words change nothing. The control word stores all 32 bits and affects nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Raw interrupt levels, bit n is source n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal request level |
| fiq_o | output | 1 | Fast request level |

## Verification
The assertions check several rules on every cycle. A number-command write lands on exactly its own enable bit in the next cycle. A chosen normal source is really normal-pending and carries the reported priority. A masked choice always lies above the mask level, and an idle normal request means an empty vector. The fast request agrees with the fast vector. The bench scenarios cover the rest. They show the priority-word layout and the tie rule toward the higher number. They show that masking hides sources from the vector while the request stays high, and that force bits, routing and writes to read-only words behave as required. Random traffic then compares every vector and pending word against a model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 64;
  localparam int PRIO_W  = 4;
  localparam int MASK_W  = 5;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_PRW = NUM_SRC * PRIO_W / DATA_W;
  localparam int PER_PRW = DATA_W / PRIO_W;
  localparam logic [MASK_W-1:0] MASK_OPEN = '1;

  // word index = byte offset / 4
  localparam logic [4:0] W_CTRL  = 5'd0;
  localparam logic [4:0] W_MASK  = 5'd1;
  localparam logic [4:0] W_ENNUM = 5'd2;
  localparam logic [4:0] W_DSNUM = 5'd3;
  localparam logic [4:0] W_ENH   = 5'd4;
  localparam logic [4:0] W_ENL   = 5'd5;
  localparam logic [4:0] W_TYH   = 5'd6;
  localparam logic [4:0] W_TYL   = 5'd7;
  localparam logic [4:0] W_PR_LO = 5'd8;
  localparam logic [4:0] W_PR_HI = 5'd15;
  localparam logic [4:0] W_NVEC  = 5'd16;
  localparam logic [4:0] W_FVEC  = 5'd17;
  localparam logic [4:0] W_RAWH  = 5'd18;
  localparam logic [4:0] W_RAWL  = 5'd19;
  localparam logic [4:0] W_FRH   = 5'd20;
  localparam logic [4:0] W_FRL   = 5'd21;
  localparam logic [4:0] W_NPH   = 5'd22;
  localparam logic [4:0] W_NPL   = 5'd23;
  localparam logic [4:0] W_FPH   = 5'd24;
  localparam logic [4:0] W_FPL   = 5'd25;

  localparam logic [DATA_W-1:0] VEC_NONE = '1;

  typedef logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr_t;
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [4:0]        word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] typ_o,
  output logic [NUM_SRC-1:0] frc_o,
  output prio_arr_t         prio_o
);
  localparam int HALF = NUM_SRC / 2;

  logic num_ok;
  assign num_ok = (wdata_i < DATA_W'(NUM_SRC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      mask_o <= MASK_OPEN;
      en_o   <= '0;
      typ_o  <= '0;
      frc_o  <= '0;
    end else if (we_i) begin
      case (word_i)
        W_CTRL:  ctrl_o <= wdata_i;
        W_MASK:  mask_o <= wdata_i[MASK_W-1:0];
        W_ENNUM: if (num_ok) en_o[wdata_i[IDX_W-1:0]] <= 1'b1;
        W_DSNUM: if (num_ok) en_o[wdata_i[IDX_W-1:0]] <= 1'b0;
        W_ENH:   en_o[NUM_SRC-1:HALF]  <= wdata_i;
        W_ENL:   en_o[HALF-1:0]        <= wdata_i;
        W_TYH:   typ_o[NUM_SRC-1:HALF] <= wdata_i;
        W_TYL:   typ_o[HALF-1:0]       <= wdata_i;
        W_FRH:   frc_o[NUM_SRC-1:HALF] <= wdata_i;
        W_FRL:   frc_o[HALF-1:0]       <= wdata_i;
        default: ;
      endcase
    end
  end

  // priority word x lives at word index W_PR_HI - x
  for (genvar x = 0; x < NUM_PRW; x++) begin : g_prw
    localparam logic [4:0] WIDX = W_PR_HI - 5'(x);
    for (genvar j = 0; j < PER_PRW; j++) begin : g_fld
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prio_o[x*PER_PRW+j] <= '0;
        else if (we_i && word_i == WIDX)
          prio_o[x*PER_PRW+j] <= wdata_i[j*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_pick_tree.sv
// Balanced pick tree: highest priority wins, right (higher index) wins ties.
module intc_pick_tree #(
  parameter int N  = 64,
  parameter int PW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  localparam int NN = 2 * N - 1;

  logic          nv [NN];
  logic [PW-1:0] np [NN];
  logic [IW-1:0] ni [NN];

  for (genvar g = 0; g < N; g++) begin : g_leaf
    assign nv[N-1+g] = valid_i[g];
    assign np[N-1+g] = prio_i[g];
    assign ni[N-1+g] = IW'(g);
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || np[2*k+2] >= np[2*k+1]);
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
  end

  assign found_o = nv[0];
  assign idx_o   = ni[0];
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import intc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int HALF = NUM_SRC / 2;
  localparam int HW   = DATA_W / 2;

  logic [4:0]         word;
  logic               unused_addr_lsb;
  logic [DATA_W-1:0]  ctrl_q;
  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC-1:0] en_q, typ_q, frc_q, raw_q;
  prio_arr_t          prio_q;
  logic [NUM_SRC-1:0] act, norm_pend, fast_pend, elig;
  logic               n_found, f_found;
  logic [IDX_W-1:0]   n_idx, f_idx;
  logic [DATA_W-1:0]  nvec, fvec;

  assign word            = addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr_i[1:0];

  intc_regfile u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .word_i (word),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl_q),
    .mask_o (mask_q),
    .en_o   (en_q),
    .typ_o  (typ_q),
    .frc_o  (frc_q),
    .prio_o (prio_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= src_i;
  end

  assign act       = (raw_q | frc_q) & en_q;
  assign norm_pend = act & ~typ_q;
  assign fast_pend = act & typ_q;
  assign irq_o     = |norm_pend;
  assign fiq_o     = |fast_pend;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = norm_pend[i] &&
                     (mask_q == MASK_OPEN || MASK_W'(prio_q[i]) > mask_q);
  end

  intc_pick_tree #(.N(NUM_SRC), .PW(PRIO_W)) u_norm_pick (
    .valid_i(elig),
    .prio_i (prio_q),
    .found_o(n_found),
    .idx_o  (n_idx)
  );

  intc_pick_tree #(.N(NUM_SRC), .PW(1)) u_fast_pick (
    .valid_i(fast_pend),
    .prio_i ('0),
    .found_o(f_found),
    .idx_o  (f_idx)
  );

  assign nvec = n_found ? {HW'(n_idx), HW'(prio_q[n_idx])} : VEC_NONE;
  assign fvec = f_found ? {HW'(f_idx), HW'(prio_q[f_idx])} : VEC_NONE;

  always_comb begin
    rdata_o = '0;
    case (word)
      W_CTRL: rdata_o = ctrl_q;
      W_MASK: rdata_o = DATA_W'(mask_q);
      W_ENH:  rdata_o = en_q[NUM_SRC-1:HALF];
      W_ENL:  rdata_o = en_q[HALF-1:0];
      W_TYH:  rdata_o = typ_q[NUM_SRC-1:HALF];
      W_TYL:  rdata_o = typ_q[HALF-1:0];
      W_NVEC: rdata_o = nvec;
      W_FVEC: rdata_o = fvec;
      W_RAWH: rdata_o = raw_q[NUM_SRC-1:HALF];
      W_RAWL: rdata_o = raw_q[HALF-1:0];
      W_FRH:  rdata_o = frc_q[NUM_SRC-1:HALF];
      W_FRL:  rdata_o = frc_q[HALF-1:0];
      W_NPH:  rdata_o = norm_pend[NUM_SRC-1:HALF];
      W_NPL:  rdata_o = norm_pend[HALF-1:0];
      W_FPH:  rdata_o = fast_pend[NUM_SRC-1:HALF];
      W_FPL:  rdata_o = fast_pend[HALF-1:0];
      default: begin
        if (word >= W_PR_LO && word <= W_PR_HI) begin
          for (int j = 0; j < PER_PRW; j++)
            rdata_o[j*PRIO_W +: PRIO_W] =
              prio_q[int'(W_PR_HI - word) * PER_PRW + j];
        end
      end
    endcase
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] norm_pend,
  input logic [MASK_W-1:0]  mask_q,
  input prio_arr_t          prio_q,
  input logic [DATA_W-1:0]  nvec,
  input logic [DATA_W-1:0]  fvec,
  input logic               irq_o,
  input logic               fiq_o
);
  logic [IDX_W-1:0]  sel_idx;
  logic [PRIO_W-1:0] sel_prio;
  logic              n_valid, num_wr;
  assign sel_idx  = nvec[16 +: IDX_W];
  assign sel_prio = prio_q[sel_idx];
  assign n_valid  = (nvec != VEC_NONE);
  assign num_wr   = we_i && (wdata_i < DATA_W'(NUM_SRC));

  a_r3_set_by_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_wr && addr_i[ADDR_W-1:2] == W_ENNUM) |=> en_q[$past(wdata_i[IDX_W-1:0])]);

  a_r3_clr_by_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_wr && addr_i[ADDR_W-1:2] == W_DSNUM) |=> !en_q[$past(wdata_i[IDX_W-1:0])]);

  a_r7_sel_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_valid |-> (norm_pend[sel_idx] && nvec[PRIO_W-1:0] == sel_prio));

  a_r8_sel_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_valid && mask_q != MASK_OPEN) |-> MASK_W'(sel_prio) > mask_q);

  a_r7_idle_no_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> !n_valid);

  a_r9_fiq_vs_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == (fvec != VEC_NONE));
endmodule

bind vec_intc vec_intc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .en_q     (en_q),
  .norm_pend(norm_pend),
  .mask_q   (mask_q),
  .prio_q   (prio_q),
  .nvec     (nvec),
  .fvec     (fvec),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src = '0;
  logic        we = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [63:0] m_en = '0, m_typ = '0, m_frc = '0, m_src = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask = 5'h1f;

  always #2 clk = ~clk;

  vec_intc u_vec_intc (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [6:0] a, input logic [31:0] d);
    int w = int'(a[6:2]);
    case (w)
      1: m_mask = d[4:0];
      2: if (d < 64) m_en[d[5:0]] = 1'b1;
      3: if (d < 64) m_en[d[5:0]] = 1'b0;
      4: m_en[63:32] = d;
      5: m_en[31:0] = d;
      6: m_typ[63:32] = d;
      7: m_typ[31:0] = d;
      20: m_frc[63:32] = d;
      21: m_frc[31:0] = d;
      default:
        if (w >= 8 && w <= 15)
          for (int j = 0; j < 8; j++) m_pr[(15 - w) * 8 + j] = d[4*j +: 4];
    endcase
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic set_src(input logic [63:0] s);
    @(negedge clk);
    src = s; m_src = s;
    @(posedge clk);
  endtask

  function automatic logic [63:0] pend(input bit fast);
    return (m_src | m_frc) & m_en & (fast ? m_typ : ~m_typ);
  endfunction

  function automatic logic [31:0] exp_nvec();
    logic [63:0] p = pend(0);
    bit found = 0;
    int bi = 0;
    for (int i = 0; i < 64; i++)
      if (p[i] && (m_mask == 5'h1f || {1'b0, m_pr[i]} > m_mask) &&
          (!found || m_pr[i] >= m_pr[bi])) begin
        found = 1; bi = i;
      end
    return found ? {16'(bi), 12'h0, m_pr[bi]} : 32'hffffffff;
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] p = pend(1);
    for (int i = 63; i >= 0; i--)
      if (p[i]) return {16'(i), 12'h0, m_pr[i]};
    return 32'hffffffff;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(7'h40, v); check({tag, " R7 nvec"}, v, exp_nvec());
    rd(7'h44, v); check({tag, " R9 fvec"}, v, exp_fvec());
    rd(7'h58, v); check({tag, " R4 npend hi"}, v, pend(0)[63:32]);
    rd(7'h5C, v); check({tag, " R4 npend lo"}, v, pend(0)[31:0]);
    rd(7'h60, v); check({tag, " R4 fpend hi"}, v, pend(1)[63:32]);
    rd(7'h64, v); check({tag, " R4 fpend lo"}, v, pend(1)[31:0]);
    check({tag, " R5 irq"}, 32'(irq), 32'(|pend(0)));
    check({tag, " R5 fiq"}, 32'(fiq), 32'(|pend(1)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(7'h00, v); check("R1 ctrl", v, 0);
    rd(7'h04, v); check("R1 mask", v, 32'h1f);
    rd(7'h10, v); check("R1 en hi", v, 0);
    rd(7'h14, v); check("R1 en lo", v, 0);
    rd(7'h1C, v); check("R1 type lo", v, 0);
    rd(7'h28, v); check("R1 prio", v, 0);
    rd(7'h40, v); check("R1 nvec", v, 32'hffffffff);
    rd(7'h44, v); check("R1 fvec", v, 32'hffffffff);
    check("R1 irq", 32'(irq), 0);
    check("R1 fiq", 32'(fiq), 0);

    // R3 number commands; R2 half split
    wr(7'h08, 5); wr(7'h08, 40);
    rd(7'h14, v); check("R3 set lo", v, 32'h20);
    rd(7'h10, v); check("R3 set hi R2", v, 32'h100);
    wr(7'h08, 64); wr(7'h0C, 32'h100);
    rd(7'h14, v); check("R3 ignore big lo", v, 32'h20);
    rd(7'h10, v); check("R3 ignore big hi", v, 32'h100);
    wr(7'h0C, 5);
    rd(7'h14, v); check("R3 clr lo", v, 0);
    rd(7'h10, v); check("R3 clr keeps hi", v, 32'h100);
    wr(7'h0C, 40);

    // R10 read-only words and control word
    wr(7'h40, 32'h1234); wr(7'h4C, 32'hffff); wr(7'h5C, 32'hff);
    rd(7'h40, v); check("R10 nvec ro", v, 32'hffffffff);
    rd(7'h4C, v); check("R10 raw ro", v, 0);
    rd(7'h5C, v); check("R10 npend ro", v, 0);
    wr(7'h00, 32'hA5A5_0F0F);
    rd(7'h00, v); check("R10 ctrl store", v, 32'hA5A5_0F0F);
    check("R10 ctrl no irq", 32'(irq), 0);
    rd(7'h68, v); check("R2 unmapped", v, 0);

    // R6 reversed priority layout
    wr(7'h20, 32'hF000_0000);  // word 7: source 63 in bits 31:28
    wr(7'h3C, 32'h0000_0050);  // word 0: source 1 in bits 7:4
    rd(7'h20, v); check("R6 readback hi", v, 32'hF000_0000);
    wr(7'h08, 63); wr(7'h08, 1);
    set_src(64'h8000_0000_0000_0002);
    rd(7'h40, v); check("R6 R7 high prio 63", v, {16'd63, 16'hF});
    wr(7'h0C, 63);
    rd(7'h40, v); check("R7 after disable", v, {16'd1, 16'h5});

    // R7 tie -> higher number; R4 force
    wr(7'h34, 32'h0005_0000);  // word 2: source 20 in bits 19:16
    wr(7'h08, 20); wr(7'h54, 32'h0010_0000);
    rd(7'h40, v); check("R7 tie R4 force", v, {16'd20, 16'h5});

    // R8 masking, R5 unaffected
    wr(7'h04, 5);
    rd(7'h40, v); check("R8 masked", v, 32'hffffffff);
    check("R5 irq while masked", 32'(irq), 1);
    wr(7'h04, 4);
    rd(7'h40, v); check("R8 above mask", v, {16'd20, 16'h5});

    // R9 fast routing
    wr(7'h1C, 32'h0010_0000);
    rd(7'h44, v); check("R9 fast sel", v, {16'd20, 16'h5});
    rd(7'h40, v); check("R9 normal left", v, {16'd1, 16'h5});
    check("R5 fiq", 32'(fiq), 1);
    check_all("directed");

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int nw = $urandom_range(3, 0);
      for (int k = 0; k < nw; k++) begin
        int sel = $urandom_range(7, 0);
        case (sel)
          0: wr(7'h10 + 7'(4 * $urandom_range(1, 0)), $urandom());
          1: wr(7'h18 + 7'(4 * $urandom_range(1, 0)), $urandom() & $urandom());
          2: wr(7'h50 + 7'(4 * $urandom_range(1, 0)), $urandom() & $urandom() & $urandom());
          3: wr(7'h20 + 7'(4 * $urandom_range(7, 0)), $urandom());
          4: wr(7'h04, ($urandom_range(1, 0) != 0) ? 32'h1f : $urandom_range(16, 0));
          5: wr(7'h08, $urandom_range(70, 0));
          6: wr(7'h0C, $urandom_range(70, 0));
          default: ;
        endcase
      end
      set_src(($urandom_range(3, 0) == 0) ? 64'h0 :
              {$urandom() & $urandom(), $urandom() & $urandom()});
      check_all("random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule